// File: doc/BRIEF.md
# Serial Control Port for a Frequency Synthesizer

This block receives a 26-bit programming word over a three-wire serial link (data, clock, enable) and turns it into the static controls of a PLL synthesizer: a 17-bit feedback divider ratio, a reference divider selection, a charge pump current code, and the states of two open-drain output ports. The three serial inputs are asynchronous to the block's system clock. They are synchronized first, and serial clock edges are detected in the system clock domain.

Bits enter a shift register only while enable is high. When enable falls, the shifted word is moved into a staging register and marked pending. The word reaches the outputs only when the feedback divider pulses its cycle-boundary tick, so a retune never breaks a divider cycle. A test bit changes the meaning of the two port bits. They then force the charge pump to sink, to source or to switch off, or they route the comparison frequency and the divider output halved onto the two ports for observation.

Top module: `synth_ctl_port`

## Requirements
- R1: After reset, every decoded field is zero, no charge pump override is active, and both ports are released (`port_sink_o` = 0).
- R2: The word is sent MSB first. Bit 25 is P1, bit 24 is P0, bit 23 is the test bit, bits 22:21 are the charge pump code, bits 20:18 are the reference index, bit 17 is the reference mode, and bits 16:0 are the divider ratio.
- R3: Serial clock rising edges while enable is low leave the shift register unchanged.
- R4: When more than 26 bits are sent in one frame, only the last 26 bits are kept.
- R5: A falling edge of enable changes no output. The word is committed on the first `div_tick_i` pulse after the falling edge.
- R6: When several frames end before a tick, the tick commits the most recent one.
- R7: `cp_code_o` carries the two charge pump current bits unchanged. Code 00 selects 0.2 mA, 01 selects 0.9 mA, 10 selects 0.1 mA and 11 selects 0.45 mA.
- R8: With the test bit at 0, `port_sink_o` equals {P1,P0} and no charge pump override is active.
- R9: With the test bit at 1, the {P1,P0} code selects the override. Code 00 asserts `cp_sink_o`, 01 asserts `cp_source_o` and 10 asserts `cp_off_o`. In these three codes both ports are released.
- R10: With the test bit at 1 and {P1,P0} = 11, `port_sink_o[1]` follows `fcomp_i` and `port_sink_o[0]` follows a divide-by-two of the tick, which toggles on every `div_tick_i` pulse and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_clk_i | input | 1 | Serial clock (asynchronous) |
| sc_data_i | input | 1 | Serial data (asynchronous) |
| sc_en_i | input | 1 | Serial enable (asynchronous) |
| div_tick_i | input | 1 | One-cycle pulse at each feedback divider cycle boundary |
| fcomp_i | input | 1 | Comparison frequency, observed in test mode |
| div_ratio_o | output | 17 | Feedback divider ratio |
| ref_mode_o | output | 1 | Reference divider mode bit |
| ref_idx_o | output | 3 | Reference divider index |
| cp_code_o | output | 2 | Charge pump current code |
| cp_sink_o | output | 1 | Charge pump forced to sink |
| cp_source_o | output | 1 | Charge pump forced to source |
| cp_off_o | output | 1 | Charge pump disabled |
| port_sink_o | output | 2 | Open-drain port pull-down enables, [1] = P1, [0] = P0 |

## Verification
The assertions check four things on every cycle. The shift register stays still while enable is low. The committed controls stay still in every cycle that is not a pending tick. At most one charge pump override is active, and an active override leaves both ports released. The tick divider toggles on each tick. Some behaviour only the bench's frames can show: that the bit order lands each field in the right place, that long frames keep their last 26 bits, that the last of several frames wins, and that each test code produces its port and pump behaviour.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int DIV_W    = 17;
  localparam int REF_W    = 3;
  localparam int CP_W     = 2;
  localparam int WORD_W   = DIV_W + REF_W + CP_W + 4;
  localparam int SYNC_LEN = 2;

  typedef struct packed {
    logic             p1;
    logic             p0;
    logic             test;
    logic [CP_W-1:0]  cp;
    logic [REF_W-1:0] ref_idx;
    logic             ref_mode;
    logic [DIV_W-1:0] div;
  } ctl_word_t;
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sc_shift.sv
module sc_shift #(
  parameter int W = synth_ctl_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         sdat_i,
  input  logic         sen_i,
  output logic [W-1:0] word_o,
  output logic         load_o
);
  logic         sclk_d_q, sen_d_q;
  logic [W-1:0] word_q, word_n;
  logic         clk_rise, shift_en;

  always_comb begin
    clk_rise = sclk_i & ~sclk_d_q;
    shift_en = clk_rise & sen_i;
    load_o   = sen_d_q & ~sen_i;
    word_n   = word_q;
    if (shift_en) word_n = {word_q[W-2:0], sdat_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      sen_d_q  <= 1'b0;
      word_q   <= '0;
    end else begin
      sclk_d_q <= sclk_i;
      sen_d_q  <= sen_i;
      word_q   <= word_n;
    end
  end

  assign word_o = word_q;

  // R3: serial clock has no effect while enable is low
  a_r3_idle_clock_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_i |=> $stable(word_q));
endmodule

// File: rtl/sc_commit.sv
module sc_commit
  import synth_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  ctl_word_t word_i,
  input  logic      tick_i,
  output ctl_word_t ctl_o,
  output logic      half_o
);
  ctl_word_t stage_q, stage_n, ctl_q, ctl_n;
  logic      pend_q, pend_n, half_q, half_n, commit;

  always_comb begin
    commit  = pend_q & tick_i;
    stage_n = load_i ? word_i : stage_q;
    ctl_n   = commit ? stage_q : ctl_q;
    pend_n  = load_i | (pend_q & ~tick_i);
    half_n  = tick_i ? ~half_q : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      ctl_q   <= '0;
      pend_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      stage_q <= stage_n;
      ctl_q   <= ctl_n;
      pend_q  <= pend_n;
      half_q  <= half_n;
    end
  end

  assign ctl_o  = ctl_q;
  assign half_o = half_q;

  // R5: controls only move on a tick that finds a pending word
  a_r5_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && tick_i) |=> $stable(ctl_q));
  // R5: a commit consumes the pending word
  a_r5_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tick_i && !load_i) |=> !pend_q);
  // R10: divided tick toggles on every tick
  a_r10_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (half_q != $past(half_q)));
endmodule

// File: rtl/sc_port_decode.sv
module sc_port_decode
  import synth_ctl_pkg::*;
(
  input  ctl_word_t   ctl_i,
  input  logic        fcomp_i,
  input  logic        half_i,
  output logic        cp_sink_o,
  output logic        cp_source_o,
  output logic        cp_off_o,
  output logic [1:0]  port_sink_o
);
  logic [1:0] code;

  always_comb begin
    code        = {ctl_i.p1, ctl_i.p0};
    cp_sink_o   = 1'b0;
    cp_source_o = 1'b0;
    cp_off_o    = 1'b0;
    port_sink_o = code;
    if (ctl_i.test) begin
      port_sink_o = 2'b00;
      case (code)
        2'b00:   cp_sink_o   = 1'b1;
        2'b01:   cp_source_o = 1'b1;
        2'b10:   cp_off_o    = 1'b1;
        default: port_sink_o = {fcomp_i, half_i};
      endcase
    end
  end
endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
  import synth_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_clk_i,
  input  logic             sc_data_i,
  input  logic             sc_en_i,
  input  logic             div_tick_i,
  input  logic             fcomp_i,
  output logic [DIV_W-1:0] div_ratio_o,
  output logic             ref_mode_o,
  output logic [REF_W-1:0] ref_idx_o,
  output logic [CP_W-1:0]  cp_code_o,
  output logic             cp_sink_o,
  output logic             cp_source_o,
  output logic             cp_off_o,
  output logic [1:0]       port_sink_o
);
  logic [2:0]        raw_s;
  logic [WORD_W-1:0] shift_word;
  logic              load;
  ctl_word_t         ctl;
  logic              half;

  sc_sync #(.W(3), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sc_en_i, sc_clk_i, sc_data_i}), .q_o(raw_s));

  sc_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(raw_s[1]), .sdat_i(raw_s[0]), .sen_i(raw_s[2]),
    .word_o(shift_word), .load_o(load));

  sc_commit u_commit (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .word_i(ctl_word_t'(shift_word)), .tick_i(div_tick_i),
    .ctl_o(ctl), .half_o(half));

  sc_port_decode u_dec (
    .ctl_i(ctl), .fcomp_i(fcomp_i), .half_i(half),
    .cp_sink_o(cp_sink_o), .cp_source_o(cp_source_o), .cp_off_o(cp_off_o),
    .port_sink_o(port_sink_o));

  assign div_ratio_o = ctl.div;
  assign ref_mode_o  = ctl.ref_mode;
  assign ref_idx_o   = ctl.ref_idx;
  assign cp_code_o   = ctl.cp;

  // R9: never more than one pump override at a time
  a_r9_one_override: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cp_sink_o, cp_source_o, cp_off_o}));
  // R9: an active override leaves both ports released
  a_r9_ports_released: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_sink_o || cp_source_o || cp_off_o) |-> (port_sink_o == 2'b00));
endmodule

// File: tb/synth_ctl_port_tb_top.sv
module synth_ctl_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_clk = 1'b0, sc_data = 1'b0, sc_en = 1'b0, tick = 1'b0, fcomp = 1'b0;
  logic [16:0] div_ratio;
  logic        ref_mode;
  logic [2:0]  ref_idx;
  logic [1:0]  cp_code;
  logic        cp_sink, cp_source, cp_off;
  logic [1:0]  port_sink;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [25:0] model_sreg = '0;
  logic        model_half = 1'b0;

  always #10 clk = ~clk;

  synth_ctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .sc_clk_i(sc_clk), .sc_data_i(sc_data),
    .sc_en_i(sc_en), .div_tick_i(tick), .fcomp_i(fcomp),
    .div_ratio_o(div_ratio), .ref_mode_o(ref_mode), .ref_idx_o(ref_idx),
    .cp_code_o(cp_code), .cp_sink_o(cp_sink), .cp_source_o(cp_source),
    .cp_off_o(cp_off), .port_sink_o(port_sink));

  // word = {P1,P0,T,C1,C0,R2,R1,R0,RD,div[16:0]} (R2)
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b0, 2'b01, 3'b101, 1'b1, 17'h1ABCD},
    {1'b1, 1'b0, 1'b0, 2'b10, 3'b011, 1'b0, 17'h00F0F},
    {1'b0, 1'b0, 1'b1, 2'b11, 3'b111, 1'b1, 17'h1FFFF},
    {1'b0, 1'b1, 1'b1, 2'b00, 3'b000, 1'b0, 17'h00000},
    {1'b1, 1'b0, 1'b1, 2'b10, 3'b010, 1'b1, 17'h10001},
    {1'b1, 1'b1, 1'b0, 2'b11, 3'b110, 1'b0, 17'h0AAAA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b, input bit en_hi);
    sc_data = b;
    wait_cyc(4);
    sc_clk = 1'b1;
    if (en_hi) model_sreg = {model_sreg[24:0], b};
    wait_cyc(4);
    sc_clk = 1'b0;
  endtask

  task automatic send(input logic [39:0] bits, input int n, input bit en_hi);
    sc_en = en_hi;
    wait_cyc(4);
    for (int i = n - 1; i >= 0; i--) ser_bit(bits[i], en_hi);
    wait_cyc(4);
    sc_en = 1'b0;
    wait_cyc(8);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    wait_cyc(1);
    tick = 1'b0;
    model_half = ~model_half;
    wait_cyc(2);
  endtask

  task automatic check_all(input string tag, input logic [25:0] w);
    logic [1:0] code;
    logic [1:0] exp_port;
    code = w[25:24];
    exp_port = w[23] ? ((code == 2'b11) ? {fcomp, model_half} : 2'b00) : code;
    chk({tag, " R2 div"}, 32'(div_ratio), 32'(w[16:0]));
    chk({tag, " R2 ref_mode"}, 32'(ref_mode), 32'(w[17]));
    chk({tag, " R2 ref_idx"}, 32'(ref_idx), 32'(w[20:18]));
    chk({tag, " R7 cp_code"}, 32'(cp_code), 32'(w[22:21]));
    chk({tag, " R8/R9 overrides"}, 32'({cp_sink, cp_source, cp_off}),
        32'(w[23] ? {code == 2'b00, code == 2'b01, code == 2'b10} : 3'b000));
    chk({tag, " R8/R9/R10 ports"}, 32'(port_sink), 32'(exp_port));
  endtask

  initial begin
    logic [25:0] cur;
    logic [25:0] fa, fb;
    cur = '0;
    wait_cyc(3);
    check_all("R1 in reset", '0);
    rst_n = 1'b1;
    wait_cyc(3);
    check_all("R1 after reset", '0);

    foreach (VEC[i]) begin
      send(40'(VEC[i]), 26, 1'b1);
      check_all("R5 hold before tick", cur);
      pulse_tick();
      cur = VEC[i];
      check_all("R2 table", cur);
    end

    // R10: observation mode on the ports
    cur = {1'b1, 1'b1, 1'b1, 2'b01, 3'b001, 1'b1, 17'h12345};
    send(40'(cur), 26, 1'b1);
    pulse_tick();
    fcomp = 1'b0;
    wait_cyc(1);
    check_all("R10 fcomp low", cur);
    fcomp = 1'b1;
    wait_cyc(1);
    check_all("R10 fcomp high", cur);
    pulse_tick();
    check_all("R10 after tick", cur);
    pulse_tick();
    check_all("R10 after second tick", cur);
    fcomp = 1'b0;

    // R6: two frames before one tick, the later wins
    fa = {1'b0, 1'b1, 1'b0, 2'b00, 3'b100, 1'b0, 17'h0F00F};
    fb = {1'b1, 1'b0, 1'b0, 2'b11, 3'b001, 1'b1, 17'h13579};
    send(40'(fa), 26, 1'b1);
    send(40'(fb), 26, 1'b1);
    check_all("R5 hold two frames", cur);
    pulse_tick();
    cur = fb;
    check_all("R6 latest frame", cur);

    // R3: clock pulses with enable low, then a short frame exposes the register
    send(40'hFF_FFFF_FFFF, 30, 1'b0);
    send(40'h2A5, 10, 1'b1);
    pulse_tick();
    cur = model_sreg;
    check_all("R3 idle clocks ignored", cur);

    // R4: 30-bit frame keeps its last 26 bits
    send({10'h000, 4'b1011, 26'h2C3_5A96}, 30, 1'b1);
    pulse_tick();
    cur = 26'h2C3_5A96;
    chk("R4 model agrees", 32'(model_sreg), 32'(cur));
    check_all("R4 long frame", cur);

    // R5: tick with nothing pending changes nothing
    pulse_tick();
    check_all("R5 idle tick", cur);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule